// File: doc/BRIEF.md
# Bus Address Tenure Controller

This block runs the address phase of a split-transaction processor bus for one master. An internal requester hands it one transfer at a time: a cache-miss burst read, a line write-back burst, or a single-beat access. The block holds that request until the external arbiter gives a grant the block can use. It then drives a transfer-start strobe and the 32-bit physical address, and keeps that address on the bus until the slave acknowledges the address phase. The bidirectional address pins appear as three signals: a driven value, an output enable and a sampled value.

Burst addresses are aligned once, when the request is accepted, and the address does not change for the whole burst. A read burst presents the double word holding the critical data that missed. A write burst presents the first double word of the cache line. One even-parity bit per address byte is driven with the address. When another master starts a transfer, the block samples the address pins in that cycle only, checks their parity, and hands the snooped address on.

The data phase, the arbitration policy and cache state are handled elsewhere.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: After reset, addr_oe, ts_out, snoop_valid and snoop_par_err are 0, and req_ready is 1.
- R2: When a request is pending and bus_grant is high in a cycle where ts_in was low in the previous cycle, the next cycle has ts_out = 1 and addr_oe = 1, with the request's address on addr_out. ts_out lasts exactly one cycle.
- R3: A grant in a cycle that directly follows a cycle with ts_in high is not qualified. It produces no ts_out and no drive in the next cycle.
- R4: While addr_oe is 1 and aack_in has not been seen, addr_out and par_out keep the value driven in the transfer-start cycle. The address is never incremented.
- R5: addr_oe stays 1 in the cycle where aack_in is high and drops to 0 in the following cycle. No extra idle or precharge cycle is added.
- R6: For a burst read (req_burst = 1, req_write = 0), addr_out equals req_addr with bits [2:0] cleared.
- R7: For a burst write (req_burst = 1, req_write = 1), addr_out equals req_addr with the low log2(LINE_BYTES) bits cleared. With the default LINE_BYTES = 32, that is bits [4:0].
- R8: For a single-beat access (req_burst = 0), addr_out equals req_addr unchanged.
- R9: While driving, par_out[i] is the XOR of addr_out[8i+7:8i]. Each byte plus its parity bit therefore holds an even number of ones.
- R10: addr_in is sampled only in a cycle where ts_in is high and the block is not driving. snoop_valid is then 1 for one cycle in the following cycle, with snoop_addr holding the sampled address. In all other cycles addr_in is ignored and snoop_addr is unchanged.
- R11: When the sampled par_in differs from the even parity of the sampled address (bit i covering byte i), snoop_par_err is 1 for exactly that snoop_valid cycle.
- R12: req_ready is 1 only when no request is pending or in tenure. A request is taken when req_valid and req_ready are both high. Requests offered while req_ready is low are dropped and cause no later tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request offered |
| req_ready | output | 1 | Block can take a request |
| req_burst | input | 1 | 1 = cache-line burst, 0 = single beat |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address (critical address for read misses) |
| bus_grant | input | 1 | Address bus grant from the arbiter |
| ts_in | input | 1 | Transfer-start seen on the bus from another master |
| ts_out | output | 1 | Transfer-start driven by this block |
| aack_in | input | 1 | Address acknowledge from the slave |
| addr_out | output | 32 | Address driven onto the bus |
| addr_oe | output | 1 | Output enable for addr_out and par_out |
| par_out | output | 4 | Even parity per driven address byte |
| addr_in | input | 32 | Address sampled from the bus pins |
| par_in | input | 4 | Parity sampled from the bus pins |
| snoop_valid | output | 1 | One-cycle strobe: a snooped address is available |
| snoop_addr | output | 32 | Last snooped address |
| snoop_par_err | output | 1 | Parity mismatch on the snooped address |

## Verification
A wrong tenure state shows at the ports within one cycle. It appears as a transfer-start with no grant, as a drive that outlives the acknowledge by one or more cycles, or as req_ready asserted while the bus is still owned. A corrupt stored address or a wrong alignment mask shows in the transfer-start cycle itself, on addr_out and par_out, and then persists for every cycle of the tenure. A snoop path that samples in the wrong cycle shows one cycle later, as a snoop_valid strobe or a change on snoop_addr that has no matching ts_in.

// File: rtl/atc_pkg.sv
`timescale 1ns/1ps
package atc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_DRIVE = 2'd2
    } tenure_st_e;
endpackage

// File: rtl/atc_align.sv
`timescale 1ns/1ps
module atc_align #(
    parameter int AW         = 32,
    parameter int BEAT_BYTES = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic [AW-1:0] raw_addr,
    input  logic          is_burst,
    input  logic          is_write,
    output logic [AW-1:0] bus_addr
);
    localparam int BEAT_LSB = $clog2(BEAT_BYTES);
    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] BEAT_MASK = {{(AW-BEAT_LSB){1'b1}}, {BEAT_LSB{1'b0}}};
    localparam logic [AW-1:0] LINE_MASK = {{(AW-LINE_LSB){1'b1}}, {LINE_LSB{1'b0}}};

    always_comb begin
        if (!is_burst) begin
            bus_addr = raw_addr;
        end else if (is_write) begin
            bus_addr = raw_addr & LINE_MASK;
        end else begin
            bus_addr = raw_addr & BEAT_MASK;
        end
    end
endmodule

// File: rtl/atc_parity.sv
`timescale 1ns/1ps
module atc_parity #(
    parameter int AW = 32
) (
    input  logic [AW-1:0]   word,
    output logic [AW/8-1:0] par
);
    localparam int NBYTES = AW / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign par[b] = ^word[8*b +: 8];
    end
endmodule

// File: rtl/atc_snoop.sv
`timescale 1ns/1ps
module atc_snoop #(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ts_seen,
    input  logic            own_drive,
    input  logic [AW-1:0]   pin_addr,
    input  logic [AW/8-1:0] pin_par,
    output logic            snp_valid,
    output logic [AW-1:0]   snp_addr,
    output logic            snp_err
);
    localparam int NBYTES = AW / 8;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [AW-1:0] addr;
    } snp_state_t;

    snp_state_t       st_d, st_q;
    logic [NBYTES-1:0] calc_par;

    atc_parity #(.AW(AW)) u_chk_par (
        .word (pin_addr),
        .par  (calc_par)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        if (ts_seen && !own_drive) begin
            st_d.valid = 1'b1;
            st_d.addr  = pin_addr;
            st_d.err   = (calc_par != pin_par);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snp_valid = st_q.valid;
    assign snp_addr  = st_q.addr;
    assign snp_err   = st_q.err;
endmodule

// File: rtl/addr_tenure_ctrl.sv
`timescale 1ns/1ps
module addr_tenure_ctrl #(
    parameter int AW         = 32,
    parameter int BEAT_BYTES = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_burst,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic            bus_grant,
    input  logic            ts_in,
    output logic            ts_out,
    input  logic            aack_in,
    output logic [AW-1:0]   addr_out,
    output logic            addr_oe,
    output logic [AW/8-1:0] par_out,
    input  logic [AW-1:0]   addr_in,
    input  logic [AW/8-1:0] par_in,
    output logic            snoop_valid,
    output logic [AW-1:0]   snoop_addr,
    output logic            snoop_par_err
);
    import atc_pkg::*;

    localparam int NBYTES = AW / 8;

    typedef struct packed {
        tenure_st_e    st;
        logic          ts;
        logic          ts_prev;
        logic [AW-1:0] addr;
    } ten_state_t;

    ten_state_t    cur_d, cur_q;
    logic [AW-1:0] aligned_addr;
    logic          grant_ok;
    logic          driving;

    atc_align #(
        .AW         (AW),
        .BEAT_BYTES (BEAT_BYTES),
        .LINE_BYTES (LINE_BYTES)
    ) u_align (
        .raw_addr (req_addr),
        .is_burst (req_burst),
        .is_write (req_write),
        .bus_addr (aligned_addr)
    );

    atc_parity #(.AW(AW)) u_drv_par (
        .word (cur_q.addr),
        .par  (par_out)
    );

    assign driving = (cur_q.st == ST_DRIVE);

    always_comb begin
        cur_d         = cur_q;
        cur_d.ts      = 1'b0;
        cur_d.ts_prev = ts_in;
        grant_ok      = bus_grant && (cur_q.st == ST_PEND) && !cur_q.ts_prev;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    cur_d.st   = ST_PEND;
                    cur_d.addr = aligned_addr;
                end
            end
            ST_PEND: begin
                if (grant_ok) begin
                    cur_d.st = ST_DRIVE;
                    cur_d.ts = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (aack_in) begin
                    cur_d.st = ST_IDLE;
                end
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, ts: 1'b0, ts_prev: 1'b0, addr: '0};
        end else begin
            cur_q <= cur_d;
        end
    end

    atc_snoop #(.AW(AW)) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .ts_seen   (ts_in),
        .own_drive (driving),
        .pin_addr  (addr_in),
        .pin_par   (par_in),
        .snp_valid (snoop_valid),
        .snp_addr  (snoop_addr),
        .snp_err   (snoop_par_err)
    );

    assign req_ready = (cur_q.st == ST_IDLE);
    assign ts_out    = cur_q.ts;
    assign addr_oe   = driving;
    assign addr_out  = cur_q.addr;
endmodule

// File: rtl/atc_checker.sv
`timescale 1ns/1ps
module atc_checker #(
    parameter int AW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            ts_in,
    input logic            ts_out,
    input logic            aack_in,
    input logic [AW-1:0]   addr_out,
    input logic            addr_oe,
    input logic [AW/8-1:0] par_out,
    input logic            snoop_valid,
    input logic            snoop_par_err
);
    logic [AW/8-1:0] exp_par;

    always_comb begin
        exp_par = '0;
        for (int b = 0; b < AW/8; b++) begin
            exp_par[b] = ^addr_out[8*b +: 8];
        end
    end

    AST_TS_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) ts_out |=> !ts_out);                          // R2
    AST_TS_WITH_OE:   assert property (@(posedge clk) disable iff (!rst_n) ts_out |-> addr_oe);                          // R2
    AST_TS_BLOCKED:   assert property (@(posedge clk) disable iff (!rst_n) $past(ts_in) |=> !ts_out);                    // R3
    AST_ADDR_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) (addr_oe && !ts_out) |-> $stable(addr_out));  // R4
    AST_HOLD_TO_AACK: assert property (@(posedge clk) disable iff (!rst_n) (addr_oe && !aack_in) |=> addr_oe);           // R4
    AST_RELEASE:      assert property (@(posedge clk) disable iff (!rst_n) (addr_oe && aack_in) |=> !addr_oe);           // R5
    AST_PARITY:       assert property (@(posedge clk) disable iff (!rst_n) addr_oe |-> (par_out == exp_par));            // R9
    AST_ERR_IN_SNOOP: assert property (@(posedge clk) disable iff (!rst_n) snoop_par_err |-> snoop_valid);               // R11
    AST_BUSY_READY:   assert property (@(posedge clk) disable iff (!rst_n) addr_oe |-> !req_ready);                      // R12
endmodule

bind addr_tenure_ctrl atc_checker #(.AW(AW)) u_atc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .ts_in         (ts_in),
    .ts_out        (ts_out),
    .aack_in       (aack_in),
    .addr_out      (addr_out),
    .addr_oe       (addr_oe),
    .par_out       (par_out),
    .snoop_valid   (snoop_valid),
    .snoop_par_err (snoop_par_err)
);

// File: tb/addr_tenure_ctrl_tb.sv
`timescale 1ns/1ps
module addr_tenure_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_burst = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        bus_grant = 1'b0;
    logic        ts_in = 1'b0;
    logic        ts_out;
    logic        aack_in = 1'b0;
    logic [31:0] addr_out;
    logic        addr_oe;
    logic [3:0]  par_out;
    logic [31:0] addr_in = '0;
    logic [3:0]  par_in = '0;
    logic        snoop_valid;
    logic [31:0] snoop_addr;
    logic        snoop_par_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    addr_tenure_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_burst (req_burst), .req_write (req_write), .req_addr (req_addr),
        .bus_grant (bus_grant), .ts_in (ts_in), .ts_out (ts_out), .aack_in (aack_in),
        .addr_out (addr_out), .addr_oe (addr_oe), .par_out (par_out),
        .addr_in (addr_in), .par_in (par_in),
        .snoop_valid (snoop_valid), .snoop_addr (snoop_addr), .snoop_par_err (snoop_par_err)
    );

    function automatic logic [3:0] even_par(input logic [31:0] a);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) p[b] = ^a[8*b +: 8];
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk(addr_oe == 1'b0, "R1 addr_oe", {31'd0, addr_oe}, 32'd0);
        chk(ts_out == 1'b0, "R1 ts_out", {31'd0, ts_out}, 32'd0);
        chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk(snoop_valid == 1'b0 && snoop_par_err == 1'b0, "R1 snoop",
            {30'd0, snoop_valid, snoop_par_err}, 32'd0);
    endtask

    task automatic run_tenure(input bit burst, input bit wr, input logic [31:0] a,
                              input logic [31:0] exp_a, input int hold, input string tag);
        chk(req_ready == 1'b1, "R12 ready before", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_burst = burst; req_write = wr; req_addr = a;
        tick();
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R12 busy after accept", {31'd0, req_ready}, 32'd0);
        chk(ts_out == 1'b0 && addr_oe == 1'b0, "R2 no drive before grant",
            {30'd0, ts_out, addr_oe}, 32'd0);
        bus_grant = 1'b1;
        tick();
        bus_grant = 1'b0;
        chk(ts_out == 1'b1 && addr_oe == 1'b1, "R2 ts and drive", {30'd0, ts_out, addr_oe}, 32'd3);
        chk(addr_out == exp_a, tag, addr_out, exp_a);
        chk(par_out == even_par(exp_a), "R9 parity", {28'd0, par_out}, {28'd0, even_par(exp_a)});
        for (int i = 0; i < hold; i++) begin
            tick();
            chk(ts_out == 1'b0, "R2 ts one cycle", {31'd0, ts_out}, 32'd0);
            chk(addr_oe == 1'b1 && addr_out == exp_a, "R4 held address", addr_out, exp_a);
        end
        aack_in = 1'b1;
        tick();
        aack_in = 1'b0;
        chk(addr_oe == 1'b0, "R5 release after aack", {31'd0, addr_oe}, 32'd0);
        chk(req_ready == 1'b1, "R12 ready after release", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic test_unqualified_grant();
        req_valid = 1'b1; req_burst = 1'b0; req_write = 1'b0; req_addr = 32'hCAFE_0001;
        tick();
        req_valid = 1'b0;
        ts_in = 1'b1; addr_in = 32'h0BAD_F00D; par_in = even_par(32'h0BAD_F00D);
        tick();
        ts_in = 1'b0; bus_grant = 1'b1;
        tick();
        chk(ts_out == 1'b0 && addr_oe == 1'b0, "R3 grant after TS ignored",
            {30'd0, ts_out, addr_oe}, 32'd0);
        tick();
        bus_grant = 1'b0;
        chk(ts_out == 1'b1 && addr_out == 32'hCAFE_0001, "R3 later grant qualifies", addr_out, 32'hCAFE_0001);
        aack_in = 1'b1;
        tick();
        aack_in = 1'b0;
        chk(addr_oe == 1'b0, "R5 release", {31'd0, addr_oe}, 32'd0);
    endtask

    task automatic test_snoop();
        ts_in = 1'b1; addr_in = 32'h8001_2340; par_in = even_par(32'h8001_2340);
        tick();
        ts_in = 1'b0; addr_in = 32'h5555_AAAA;
        chk(snoop_valid == 1'b1 && snoop_addr == 32'h8001_2340, "R10 capture", snoop_addr, 32'h8001_2340);
        chk(snoop_par_err == 1'b0, "R11 good parity", {31'd0, snoop_par_err}, 32'd0);
        tick();
        chk(snoop_valid == 1'b0 && snoop_addr == 32'h8001_2340, "R10 ignored without TS",
            snoop_addr, 32'h8001_2340);
        ts_in = 1'b1; addr_in = 32'h1357_9BDF; par_in = even_par(32'h1357_9BDF) ^ 4'b0100;
        tick();
        ts_in = 1'b0;
        chk(snoop_valid == 1'b1 && snoop_par_err == 1'b1, "R11 parity error",
            {30'd0, snoop_valid, snoop_par_err}, 32'd3);
        tick();
        chk(snoop_par_err == 1'b0, "R11 one-cycle pulse", {31'd0, snoop_par_err}, 32'd0);
    endtask

    task automatic test_dropped_request();
        req_valid = 1'b1; req_burst = 1'b0; req_addr = 32'h0000_1111;
        tick();
        req_addr = 32'h0000_2222;
        tick();
        req_valid = 1'b0;
        bus_grant = 1'b1;
        tick();
        bus_grant = 1'b0;
        chk(addr_out == 32'h0000_1111, "R12 busy request dropped", addr_out, 32'h0000_1111);
        aack_in = 1'b1;
        tick();
        aack_in = 1'b0;
        bus_grant = 1'b1;
        tick();
        tick();
        bus_grant = 1'b0;
        chk(ts_out == 1'b0 && addr_oe == 1'b0, "R12 no stray tenure", {30'd0, ts_out, addr_oe}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        run_tenure(1'b1, 1'b0, 32'h1234_567D, 32'h1234_5678, 2, "R6 burst read critical dword");
        run_tenure(1'b1, 1'b1, 32'hABCD_EF3C, 32'hABCD_EF20, 3, "R7 burst write line start");
        run_tenure(1'b0, 1'b0, 32'h0000_0FFB, 32'h0000_0FFB, 0, "R8 single beat address");
        run_tenure(1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R8 single write address");
        test_unqualified_grant();
        test_snoop();
        test_dropped_request();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule